// File: doc/BRIEF.md
# Indexed Four-Way Dot-Product Accumulator

This block is a single-stage vector datapath that widens and accumulates unsigned dot products. A vector of `VL` bits is treated as a row of wide elements of 32 or 64 bits. Each wide element is made of four unsigned narrow parts of 8 or 16 bits.

For every wide element, the block multiplies the four narrow parts of the first operand by four narrow parts of the second operand and adds the four products into the matching element of an accumulator vector. The four parts of the second operand do not come from the same lane. They come from one group inside the same 128-bit segment, and a small immediate index picks that group. Every element in a segment therefore reuses the same broadcast group.

The sums wrap at the element width. The result is presented one clock after a valid input. The time to a result is fixed and does not depend on operand values. Whatever supplies the operands keeps `VL` at a multiple of 128.

Top module: `idot4_acc`

## Requirements
- R1: With `esz_sel`=0 (32-bit elements of four 8-bit parts), the result has one entry per element e. The entry is acc[e] plus the sum over i=0..3 of a-part(4e+i) times b-part(4s+i), where s = e − (e mod 4) + `idx`. Part p occupies bits [8p+7:8p].
- R2: With `esz_sel`=1 (64-bit elements of four 16-bit parts) and `idx` of 0 or 1, the same sum is formed with s = e − (e mod 2) + `idx`. Part p occupies bits [16p+15:16p].
- R3: The group chosen by `idx` sits at the same position in every 128-bit segment, so elements in different segments read different groups of the second operand.
- R4: Accumulation wraps modulo 2^32 or 2^64 with no saturation.
- R5: `valid_out` is `valid_in` delayed by exactly one clock. The result belongs to the operands sampled on that edge, whatever their values.
- R6: With `esz_sel`=1 and `idx` of 2 or 3, `idx_err` is 1 together with `valid_out`, and `acc_out` equals the sampled accumulator unchanged.
- R7: While `valid_in` is 0, `acc_out` holds its value and `idx_err` is 0, whatever the other inputs do.
- R8: During reset, `valid_out`, `idx_err` and `acc_out` are all zero.
- R9: A valid operation in 32-bit mode, or in 64-bit mode with an in-range index, never raises `idx_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands valid this cycle |
| esz_sel | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| idx | input | 2 | Group index within each 128-bit segment |
| src_a | input | VL | First operand vector |
| src_b | input | VL | Second operand vector (indexed) |
| acc_in | input | VL | Accumulator vector |
| valid_out | output | 1 | Result valid |
| idx_err | output | 1 | Index out of range for the selected size |
| acc_out | output | VL | Updated accumulator vector |

## Verification
Saturated operands of all ones in both sizes separate a wrapping adder from a saturating or widened one. Each index is driven with a second operand whose groups all differ, so a wrong group or a lane-aligned read gives a different sum. The two segments are also loaded with different contents, which exposes a group taken from the wrong segment. Random operands over both sizes and all indices cover general carries. Out-of-range 64-bit indices, and input changes while idle, show whether the accumulator passes through or holds as specified.

// File: rtl/idot_pkg.sv
package idot_pkg;

    localparam int SEG_W = 128;

    typedef enum logic {
        ESZ_W32 = 1'b0,
        ESZ_W64 = 1'b1
    } esz_e;

endpackage

// File: rtl/idot_dot4.sv
// One wide element: four zero-extended part products summed into the
// accumulator element, wrapping at the element width.
module idot_dot4 #(
    parameter int SUBW = 8
) (
    input  logic [4*SUBW-1:0] a_el,
    input  logic [4*SUBW-1:0] b_grp,
    input  logic [4*SUBW-1:0] acc_el,
    output logic [4*SUBW-1:0] sum_el
);
    localparam int EW = 4 * SUBW;

    logic [EW-1:0] prod [4];

    for (genvar i = 0; i < 4; i++) begin : g_prod
        assign prod[i] = EW'(a_el[i*SUBW +: SUBW]) * EW'(b_grp[i*SUBW +: SUBW]);
    end

    always_comb begin
        sum_el = acc_el + prod[0] + prod[1] + prod[2] + prod[3];
    end
endmodule

// File: rtl/idot_segment.sv
// One 128-bit segment: picks the indexed group of the second operand and
// computes both element-size variants, then selects one.
module idot_segment
    import idot_pkg::*;
(
    input  logic [SEG_W-1:0] a_seg,
    input  logic [SEG_W-1:0] b_seg,
    input  logic [SEG_W-1:0] acc_seg,
    input  esz_e             esz,
    input  logic [1:0]       idx,
    output logic [SEG_W-1:0] res_seg
);
    localparam int N32 = SEG_W / 32;
    localparam int N64 = SEG_W / 64;

    logic [31:0]      grp32_d;
    logic [63:0]      grp64_d;
    logic [SEG_W-1:0] res32_d;
    logic [SEG_W-1:0] res64_d;

    always_comb begin
        grp32_d = b_seg[32*idx +: 32];
        grp64_d = b_seg[64*idx[0] +: 64];
    end

    for (genvar k = 0; k < N32; k++) begin : g_w32
        idot_dot4 #(.SUBW(8)) u_dot (
            .a_el   (a_seg[32*k +: 32]),
            .b_grp  (grp32_d),
            .acc_el (acc_seg[32*k +: 32]),
            .sum_el (res32_d[32*k +: 32])
        );
    end

    for (genvar k = 0; k < N64; k++) begin : g_w64
        idot_dot4 #(.SUBW(16)) u_dot (
            .a_el   (a_seg[64*k +: 64]),
            .b_grp  (grp64_d),
            .acc_el (acc_seg[64*k +: 64]),
            .sum_el (res64_d[64*k +: 64])
        );
    end

    always_comb begin
        res_seg = (esz == ESZ_W64) ? res64_d : res32_d;
    end
endmodule

// File: rtl/idot4_acc.sv
module idot4_acc
    import idot_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_in,
    input  logic          esz_sel,
    input  logic [1:0]    idx,
    input  logic [VL-1:0] src_a,
    input  logic [VL-1:0] src_b,
    input  logic [VL-1:0] acc_in,
    output logic          valid_out,
    output logic          idx_err,
    output logic [VL-1:0] acc_out
);
    localparam int NSEG = VL / SEG_W;

    typedef struct packed {
        logic          vld;
        logic          err;
        logic [VL-1:0] acc;
    } stage_t;

    stage_t        st_d, st_q;
    esz_e          esz_d;
    logic          bad_idx_d;
    logic [VL-1:0] calc_d;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        idot_segment u_seg (
            .a_seg   (src_a[SEG_W*g +: SEG_W]),
            .b_seg   (src_b[SEG_W*g +: SEG_W]),
            .acc_seg (acc_in[SEG_W*g +: SEG_W]),
            .esz     (esz_d),
            .idx     (idx),
            .res_seg (calc_d[SEG_W*g +: SEG_W])
        );
    end

    always_comb begin
        esz_d     = esz_e'(esz_sel);
        bad_idx_d = (esz_d == ESZ_W64) && idx[1];
        st_d      = st_q;
        st_d.vld  = valid_in;
        st_d.err  = 1'b0;
        if (valid_in) begin
            st_d.err = bad_idx_d;
            st_d.acc = bad_idx_d ? acc_in : calc_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out = st_q.vld;
    assign idx_err   = st_q.err;
    assign acc_out   = st_q.acc;
endmodule

// File: rtl/idot_chk.sv
module idot_chk #(
    parameter int VL = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_in,
    input logic          esz_sel,
    input logic [1:0]    idx,
    input logic [VL-1:0] acc_in,
    input logic          valid_out,
    input logic          idx_err,
    input logic [VL-1:0] acc_out
);
    assert_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    assert_lat_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && esz_sel && idx[1]) |=> (idx_err && acc_out == $past(acc_in)));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> ($stable(acc_out) && !idx_err));
    assert_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !(esz_sel && idx[1])) |=> !idx_err);
endmodule

bind idot4_acc idot_chk #(.VL(VL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .esz_sel   (esz_sel),
    .idx       (idx),
    .acc_in    (acc_in),
    .valid_out (valid_out),
    .idx_err   (idx_err),
    .acc_out   (acc_out)
);

// File: tb/idot4_acc_tb.sv
`timescale 1ns/1ps
module idot4_acc_tb;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          valid_in;
    logic          esz_sel;
    logic [1:0]    idx;
    logic [VL-1:0] src_a, src_b, acc_in;
    logic          valid_out, idx_err;
    logic [VL-1:0] acc_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    idot4_acc #(.VL(VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .esz_sel(esz_sel),
        .idx(idx), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .valid_out(valid_out), .idx_err(idx_err), .acc_out(acc_out)
    );

    function automatic logic [VL-1:0] model(input logic [VL-1:0] a, input logic [VL-1:0] b,
                                            input logic [VL-1:0] acc, input logic sel,
                                            input logic [1:0] ix);
        logic [VL-1:0] r;
        logic [63:0]   sm;
        int            s;
        r = acc;
        if (sel && ix[1]) return acc;
        if (!sel) begin
            for (int e = 0; e < VL/32; e++) begin
                s  = e - (e % 4) + int'(ix);
                sm = 64'(acc[e*32 +: 32]);
                for (int i = 0; i < 4; i++)
                    sm = sm + 64'(a[(4*e+i)*8 +: 8]) * 64'(b[(4*s+i)*8 +: 8]);
                r[e*32 +: 32] = sm[31:0];
            end
        end else begin
            for (int e = 0; e < VL/64; e++) begin
                s  = e - (e % 2) + int'(ix[0]);
                sm = acc[e*64 +: 64];
                for (int i = 0; i < 4; i++)
                    sm = sm + 64'(a[(4*e+i)*16 +: 16]) * 64'(b[(4*s+i)*16 +: 16]);
                r[e*64 +: 64] = sm;
            end
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int w = 0; w < VL/32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk_vec(input string req, input logic [VL-1:0] got, input logic [VL-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s acc_out actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic chk_bit(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    // Drive one operation at a negedge; the result is registered at the
    // following posedge and sampled at the next negedge.
    task automatic run_op(input string req, input logic [VL-1:0] a, input logic [VL-1:0] b,
                          input logic [VL-1:0] acc, input logic sel, input logic [1:0] ix);
        logic bad;
        bad = sel && ix[1];
        @(negedge clk);
        valid_in = 1'b1; esz_sel = sel; idx = ix;
        src_a = a; src_b = b; acc_in = acc;
        @(negedge clk);
        valid_in = 1'b0;
        chk_bit(req, "valid_out", valid_out, 1'b1);
        chk_bit(bad ? "R6" : "R9", "idx_err", idx_err, bad);
        chk_vec(req, acc_out, model(a, b, acc, sel, ix));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] b_tag, prev;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; valid_in = 1'b0; esz_sel = 1'b0; idx = 2'd0;
        src_a = '0; src_b = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        chk_bit("R8", "valid_out", valid_out, 1'b0);
        chk_bit("R8", "idx_err", idx_err, 1'b0);
        chk_vec("R8", acc_out, '0);
        rst_n = 1'b1;

        // R4: saturated operands wrap in both sizes
        run_op("R4", '1, '1, '1, 1'b0, 2'd3);
        run_op("R4", '1, '1, '1, 1'b1, 2'd1);

        // R1/R3: distinct group contents in each segment and every index
        for (int g = 0; g < VL/32; g++) b_tag[g*32 +: 32] = 32'h01010101 * (g + 1);
        for (int k = 0; k < 4; k++)
            run_op("R1_R3", rnd_vec(), b_tag, rnd_vec(), 1'b0, 2'(k));
        // R2/R3: 64-bit mode, both valid indices
        for (int k = 0; k < 2; k++)
            run_op("R2_R3", rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, 2'(k));

        // R6: out-of-range indices pass the accumulator through
        run_op("R6", rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, 2'd2);
        run_op("R6", rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, 2'd3);

        // R5: valid drops one cycle after the single-cycle pulse
        @(negedge clk);
        chk_bit("R5", "valid_out", valid_out, 1'b0);

        // R7: idle inputs change but outputs hold
        prev = acc_out;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            src_a = rnd_vec(); src_b = rnd_vec(); acc_in = rnd_vec();
            esz_sel = 1'($urandom); idx = 2'($urandom);
            @(negedge clk);
            chk_vec("R7", acc_out, prev);
            chk_bit("R7", "idx_err", idx_err, 1'b0);
        end

        // Random mix over sizes and indices (R1, R2, R3, R5, R6)
        for (int n = 0; n < 300; n++) begin
            logic sel;
            logic [1:0] ix;
            sel = 1'($urandom);
            ix  = 2'($urandom);
            run_op(sel ? "R2_R3_rand" : "R1_R3_rand", rnd_vec(), rnd_vec(), rnd_vec(), sel, ix);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule